// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block is the interrupt acceptance core that sits beside one processor. It keeps three vector-wide bitmaps: pending requests, vectors currently in service, and the trigger mode recorded for each vector. It also keeps a task-priority value and a spurious-vector register whose top bit enables the whole core. Requests arrive on a set port as a vector number plus a level/edge flag. The core raises `irq_pending` whenever the best pending request outranks the current processor priority. The processor then asks for a vector on the acknowledge port and later signals completion with an end-of-interrupt strobe.

Priority is judged in classes of 16 vectors (vector bits [7:4] at the default size). The processor priority is the larger of two values: the task priority, and the class of the highest in-service vector shifted left by four. An acknowledge that the task priority masks returns the spurious vector and leaves the pending set unchanged.

Both the set port and the acknowledge request port are valid/ready streams. Their ready outputs are tied high, so a beat is taken in every cycle its valid is high and there is no back-pressure. The acknowledge response is a registered one-cycle pulse with no ready. The processor must take it in the cycle it appears.

Top module: `vic_core`

## Requirements
- R1: After reset the pending, in-service and trigger-mode bitmaps and the task priority are zero, and the spurious register holds 0x0FF (enable bit 8 clear, spurious vector 0xFF), so `irq_pending` is low.
- R2: A set beat sets the pending bit of `set_vector`. It sets that vector's trigger-mode bit when `set_level` is 1 and clears it when `set_level` is 0. A later beat for the same vector overwrites the mode.
- R3: `irq_pending` is high exactly when the core is enabled, some vector is pending, and either the processor priority is zero or the class of the highest pending vector is strictly greater than the class of the processor priority.
- R4: The processor priority equals the task priority when the task-priority class is at least the class of the highest in-service vector. Otherwise it equals that in-service class shifted left by four. An empty in-service set counts as class 0.
- R5: An acknowledge while enabled, with something pending, a nonzero task priority and a highest pending vector numerically at most the task priority returns kind 2 (spurious) with vector = spurious register bits [7:0]. Pending and in-service bits are left unchanged.
- R6: Any other enabled acknowledge with something pending returns kind 1 (vector) with the highest pending vector. It clears that pending bit, sets the matching in-service bit and reports the vector's trigger-mode bit on `ack_rsp_level`. `ack_rsp_level` is 0 for every other kind.
- R7: An acknowledge while disabled or with nothing pending returns kind 0 (none) with vector 0 and changes no state.
- R8: An end-of-interrupt strobe clears the highest set in-service bit. It does nothing when the in-service set is empty.
- R9: A task-priority write stores the 4-bit `tpr_wdata` shifted left by four, so the task priority takes the form class<<4.
- R10: A spurious-register write stores all 9 bits of `svr_wdata`. Bit 8 enables the core and bits [7:0] give the spurious vector.
- R11: Each accepted acknowledge request produces exactly one response in the following cycle. In a cycle that carries several operations, the acknowledge and the end-of-interrupt act on the state from before that cycle. A set takes precedence over a pending-bit clear in the same cycle, and an in-service set takes precedence over an in-service clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Set-request beat valid |
| set_ready | output | 1 | Always 1: set beats are never stalled |
| set_vector | input | 8 | Vector to raise |
| set_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| ack_valid | input | 1 | Acknowledge request from the processor |
| ack_ready | output | 1 | Always 1 |
| ack_rsp_valid | output | 1 | Acknowledge response pulse, one cycle after the request |
| ack_rsp_kind | output | 2 | 0 none, 1 vector, 2 spurious |
| ack_rsp_vector | output | 8 | Returned vector |
| ack_rsp_level | output | 1 | Trigger mode of the granted vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task-priority write enable |
| tpr_wdata | input | 4 | Task-priority class to store |
| svr_we | input | 1 | Spurious-register write enable |
| svr_wdata | input | 9 | Enable bit 8 and spurious vector bits [7:0] |
| irq_pending | output | 1 | Interrupt request to the processor |

## Verification
The assertions check these invariants on every cycle. The pending line never rises while the core is disabled or nothing is pending. Every acknowledge request produces one response on the next cycle. A granted vector is present in the in-service set when its response appears. A spurious response carries the spurious byte from the previous cycle. A set beat leaves its pending bit set. Other behaviour needs the bench's scenarios and its reference model. This covers the class comparison that folds task priority together with in-service state, the choice between a masked and a granted acknowledge, the highest-first order of end-of-interrupt, and the ordering rules when several operations land in the same cycle.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_VEC  = 2'd1,
    ACK_SPUR = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/vic_msb_find.sv
// Highest set bit of a wide bitmap, found in two levels: per group, then across groups.
module vic_msb_find #(
  parameter int WIDTH = 256,
  parameter int GROUP = 16,
  localparam int IDX_W = $clog2(WIDTH),
  localparam int NG    = WIDTH / GROUP,
  localparam int GW    = $clog2(GROUP),
  localparam int NGW   = IDX_W - GW
) (
  input  logic [WIDTH-1:0] bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [NG-1:0] grp_any;
  logic [GW-1:0] grp_idx [NG];
  logic [NGW-1:0] top_g;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_any[g] = |bits[g*GROUP +: GROUP];
    always_comb begin
      grp_idx[g] = '0;
      for (int j = 0; j < GROUP; j++) begin
        if (bits[g*GROUP + j]) grp_idx[g] = GW'(j);
      end
    end
  end

  always_comb begin
    top_g = '0;
    for (int g = 0; g < NG; g++) begin
      if (grp_any[g]) top_g = NGW'(g);
    end
  end

  assign found = |grp_any;
  assign idx   = {top_g, grp_idx[top_g]};
endmodule

// File: rtl/vic_onehot.sv
module vic_onehot #(
  parameter int N = 256,
  localparam int IW = $clog2(N)
) (
  input  logic          en,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  mask
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign mask[i] = en && (idx == IW'(i));
  end
endmodule

// File: rtl/vic_prio_eval.sv
// Processor-priority derivation, pending decision and acknowledge classification.
module vic_prio_eval
  import vic_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int SUB_W = 4,
  localparam int CLS_W = VEC_W - SUB_W
) (
  input  logic             enable,
  input  logic [VEC_W-1:0] tpr,
  input  logic             irr_any,
  input  logic [VEC_W-1:0] irr_top,
  input  logic             isr_any,
  input  logic [CLS_W-1:0] isr_cls,
  output logic             pending,
  output ack_kind_e        kind
);
  logic [CLS_W-1:0] tpr_cls, act_cls, irr_cls, ppr_cls;
  logic [VEC_W-1:0] ppr;

  assign tpr_cls = tpr[VEC_W-1 -: CLS_W];
  assign act_cls = isr_any ? isr_cls : '0;
  assign ppr     = (tpr_cls >= act_cls) ? tpr : {act_cls, {SUB_W{1'b0}}};
  assign ppr_cls = ppr[VEC_W-1 -: CLS_W];
  assign irr_cls = irr_top[VEC_W-1 -: CLS_W];

  assign pending = enable && irr_any && ((ppr == '0) || (irr_cls > ppr_cls));

  always_comb begin
    if (!enable || !irr_any)                    kind = ACK_NONE;
    else if ((tpr != '0) && (irr_top <= tpr))   kind = ACK_SPUR;
    else                                        kind = ACK_VEC;
  end
endmodule

// File: rtl/vic_core.sv
module vic_core
  import vic_pkg::*;
#(
  parameter int NUM_VEC    = 256,
  parameter int CLASS_SIZE = 16,
  localparam int VEC_W = $clog2(NUM_VEC),
  localparam int SUB_W = $clog2(CLASS_SIZE),
  localparam int CLS_W = VEC_W - SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_valid,
  output logic             set_ready,
  input  logic [VEC_W-1:0] set_vector,
  input  logic             set_level,
  input  logic             ack_valid,
  output logic             ack_ready,
  output logic             ack_rsp_valid,
  output logic [1:0]       ack_rsp_kind,
  output logic [VEC_W-1:0] ack_rsp_vector,
  output logic             ack_rsp_level,
  input  logic             eoi,
  input  logic             tpr_we,
  input  logic [CLS_W-1:0] tpr_wdata,
  input  logic             svr_we,
  input  logic [VEC_W:0]   svr_wdata,
  output logic             irq_pending
);
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [VEC_W-1:0]   tpr_q;
  logic [VEC_W:0]     svr_q;

  logic               irr_any, isr_any;
  logic [VEC_W-1:0]   irr_top, isr_top;
  ack_kind_e          kind;
  logic               grant;
  logic [NUM_VEC-1:0] set_mask, grant_mask, eoi_mask;

  assign set_ready = 1'b1;
  assign ack_ready = 1'b1;

  vic_msb_find #(.WIDTH(NUM_VEC), .GROUP(CLASS_SIZE)) u_irr_find (
    .bits(irr_q), .found(irr_any), .idx(irr_top));
  vic_msb_find #(.WIDTH(NUM_VEC), .GROUP(CLASS_SIZE)) u_isr_find (
    .bits(isr_q), .found(isr_any), .idx(isr_top));

  vic_prio_eval #(.VEC_W(VEC_W), .SUB_W(SUB_W)) u_eval (
    .enable  (svr_q[VEC_W]),
    .tpr     (tpr_q),
    .irr_any (irr_any),
    .irr_top (irr_top),
    .isr_any (isr_any),
    .isr_cls (isr_top[VEC_W-1 -: CLS_W]),
    .pending (irq_pending),
    .kind    (kind)
  );

  assign grant = ack_valid && (kind == ACK_VEC);

  vic_onehot #(.N(NUM_VEC)) u_set_dec   (.en(set_valid),      .idx(set_vector), .mask(set_mask));
  vic_onehot #(.N(NUM_VEC)) u_grant_dec (.en(grant),          .idx(irr_top),    .mask(grant_mask));
  vic_onehot #(.N(NUM_VEC)) u_eoi_dec   (.en(eoi && isr_any), .idx(isr_top),    .mask(eoi_mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
      tpr_q <= '0;
      svr_q <= {1'b0, {VEC_W{1'b1}}};
    end else begin
      irr_q <= (irr_q & ~grant_mask) | set_mask;
      isr_q <= (isr_q & ~eoi_mask) | grant_mask;
      if (set_valid) tmr_q <= set_level ? (tmr_q | set_mask) : (tmr_q & ~set_mask);
      if (tpr_we)    tpr_q <= {tpr_wdata, {SUB_W{1'b0}}};
      if (svr_we)    svr_q <= svr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_rsp_valid  <= 1'b0;
      ack_rsp_kind   <= ACK_NONE;
      ack_rsp_vector <= '0;
      ack_rsp_level  <= 1'b0;
    end else begin
      ack_rsp_valid <= ack_valid;
      if (ack_valid) begin
        ack_rsp_kind <= kind;
        unique case (kind)
          ACK_VEC: begin
            ack_rsp_vector <= irr_top;
            ack_rsp_level  <= tmr_q[irr_top];
          end
          ACK_SPUR: begin
            ack_rsp_vector <= svr_q[VEC_W-1:0];
            ack_rsp_level  <= 1'b0;
          end
          default: begin
            ack_rsp_vector <= '0;
            ack_rsp_level  <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk #(
  parameter int NUM_VEC = 256,
  localparam int VEC_W = $clog2(NUM_VEC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               set_valid,
  input logic [VEC_W-1:0]   set_vector,
  input logic               ack_valid,
  input logic               eoi,
  input logic               ack_rsp_valid,
  input logic [1:0]         ack_rsp_kind,
  input logic [VEC_W-1:0]   ack_rsp_vector,
  input logic               irq_pending,
  input logic [NUM_VEC-1:0] irr_q,
  input logic [NUM_VEC-1:0] isr_q,
  input logic [VEC_W:0]     svr_q
);
  a_r3_pend_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> svr_q[VEC_W]);
  a_r3_pend_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (irr_q != '0));
  a_r11_one_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> ack_rsp_valid);
  a_r11_no_extra_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> !ack_rsp_valid);
  a_r6_grant_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rsp_valid && ack_rsp_kind == 2'd1) |-> isr_q[ack_rsp_vector]);
  a_r5_spur_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rsp_valid && ack_rsp_kind == 2'd2) |-> (ack_rsp_vector == $past(svr_q[VEC_W-1:0])));
  a_r2_set_pending: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> irr_q[$past(set_vector)]);
  a_r8_eoi_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_valid && isr_q == '0) |=> (isr_q == '0));
endmodule

bind vic_core vic_core_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vector(set_vector),
  .ack_valid(ack_valid), .eoi(eoi), .ack_rsp_valid(ack_rsp_valid),
  .ack_rsp_kind(ack_rsp_kind), .ack_rsp_vector(ack_rsp_vector),
  .irq_pending(irq_pending), .irr_q(irr_q), .isr_q(isr_q), .svr_q(svr_q));

// File: tb/vic_core_test.sv
module vic_core_test;
  logic clk = 0, rst_n = 0;
  logic set_valid = 0, set_level = 0, ack_valid = 0, eoi = 0, tpr_we = 0, svr_we = 0;
  logic [7:0] set_vector = 0;
  logic [3:0] tpr_wdata = 0;
  logic [8:0] svr_wdata = 0;
  logic set_ready, ack_ready, ack_rsp_valid, ack_rsp_level, irq_pending;
  logic [1:0] ack_rsp_kind;
  logic [7:0] ack_rsp_vector;

  int checks = 0, errors = 0;
  bit done = 0;
  string ctx = "";

  // Behavioural reference state
  logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
  int m_tpr = 0;
  logic [8:0] m_svr = 9'h0FF;

  always #2 clk = ~clk;

  vic_core uut (.*);

  function automatic int top_of(logic [255:0] v);
    int r = -1;
    for (int i = 0; i < 256; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic int model_ppr();
    int st = top_of(m_isr);
    int sc = (st < 0) ? 0 : st / 16;
    return ((m_tpr / 16) >= sc) ? m_tpr : sc * 16;
  endfunction

  function automatic bit model_pend();
    int it = top_of(m_irr);
    int p = model_ppr();
    if (!m_svr[8] || it < 0) return 0;
    return (p == 0) || ((it / 16) > (p / 16));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s]: actual %0h expected %0h", req, ctx, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // One cycle: drive, predict, clock, compare.
  task automatic step(bit sv, int vec, bit lvl, bit av, bit e,
                      bit twe, int tdat, bit swe, int sdat);
    int it, st, ekind, evec, elvl;
    set_valid = sv; set_vector = vec[7:0]; set_level = lvl;
    ack_valid = av; eoi = e; tpr_we = twe; tpr_wdata = tdat[3:0];
    svr_we = swe; svr_wdata = sdat[8:0];
    it = top_of(m_irr);
    st = top_of(m_isr);
    ekind = 0; evec = 0; elvl = 0;
    if (m_svr[8] && it >= 0) begin
      if (m_tpr != 0 && it <= m_tpr) begin ekind = 2; evec = m_svr[7:0]; end
      else begin ekind = 1; evec = it; elvl = m_tmr[it]; end
    end
    if (av && ekind == 1) begin m_irr[it] = 0; end
    if (e && st >= 0) m_isr[st] = 0;
    if (av && ekind == 1) m_isr[it] = 1;
    if (sv) begin m_irr[vec] = 1; m_tmr[vec] = lvl; end
    if (twe) m_tpr = tdat * 16;
    if (swe) m_svr = sdat[8:0];
    @(posedge clk);
    #1;
    chk("R3", irq_pending, model_pend());
    chk("R11", ack_rsp_valid, av);
    if (av) begin
      string rq = (ekind == 0) ? "R7" : (ekind == 2) ? "R5" : "R6";
      chk(rq, ack_rsp_kind, ekind);
      chk(rq, ack_rsp_vector, evec);
      chk(rq, ack_rsp_level, elvl);
    end
    @(negedge clk);
    set_valid = 0; ack_valid = 0; eoi = 0; tpr_we = 0; svr_we = 0;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic raise(int v, bit l); step(1, v, l, 0, 0, 0, 0, 0, 0); endtask
  task automatic ack(); step(0, 0, 0, 1, 0, 0, 0, 0, 0); endtask
  task automatic end_int(); step(0, 0, 0, 0, 1, 0, 0, 0, 0); endtask
  task automatic wr_tpr(int t); step(0, 0, 0, 0, 0, 1, t, 0, 0); endtask
  task automatic wr_svr(int s); step(0, 0, 0, 0, 0, 0, 0, 1, s); endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    ctx = "R1 reset state";
    #1;
    chk("R1", irq_pending, 0);
    chk("R1", set_ready, 1);
    chk("R1", ack_ready, 1);
    ack();                                   // R1/R7: nothing pending, disabled

    ctx = "R7 disabled core";
    raise(8'h40, 0);                         // R3: still low, core disabled
    ack();                                   // R7: none, IRR untouched

    ctx = "R10 enable";
    wr_svr(9'h1F0);                          // R10: enable, spurious 0xF0
    ack();                                   // R6: 0x40 granted, level 0

    ctx = "R4 in-service class masks lower class";
    raise(8'h55, 1);
    raise(8'h30, 0);
    ack();                                   // 0x55 level 1
    idle();                                  // R4: 0x30 class 3 below ISR class 5
    ack();                                   // acknowledge ignores ISR: 0x30

    ctx = "R8 end of interrupt order";
    raise(8'h20, 0);                         // R4: below class 5 in service
    end_int();                               // clears 0x55
    end_int();                               // clears 0x40
    end_int();                               // clears 0x30 -> 0x20 can signal
    end_int();                               // R8: empty ISR no-op
    ack();

    ctx = "R9 task priority";
    wr_tpr(5);                               // R9: 0x50
    raise(8'h50, 0);                         // R5: 0x50 <= 0x50
    ack();                                   // spurious 0xF0, IRR kept
    raise(8'h52, 0);                         // class 5 not above 5 -> R3 low
    ack();                                   // 0x52 > 0x50 -> granted
    wr_tpr(0);
    ack();                                   // 0x50 granted now
    end_int(); end_int();

    ctx = "R2 trigger mode rewrite";
    raise(8'h60, 1);
    raise(8'h60, 0);
    ack();                                   // R2: level 0
    raise(8'h61, 1);
    ack();                                   // R2: level 1
    end_int(); end_int();

    ctx = "R11 same-cycle set and grant";
    raise(8'h70, 0);
    step(1, 8'h70, 1, 1, 0, 0, 0, 0, 0);    // R11: set wins over grant clear
    step(0, 0, 0, 1, 1, 0, 0, 0, 0);        // R11: eoi on old ISR, ack re-sets
    end_int(); end_int(); end_int();

    ctx = "R10 disable";
    raise(8'hA0, 0);
    wr_svr(9'h0F0);                          // R10: disabled, pending low
    ack();                                   // R7
    wr_svr(9'h133);                          // R10: spurious 0x33
    wr_tpr(15);
    ack();                                   // R5: 0x33
    wr_tpr(0);

    ctx = "mixed traffic";
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom % 100);
      step(r < 40, int'($urandom % 256), r[0], (r % 3) == 0, (r % 4) == 1,
           r > 95, int'($urandom % 16), r == 50, (r % 7 == 0) ? 9'h0E7 : 9'h1E7);
    end
    finish_run();
  end
endmodule